// File: doc/BRIEF.md
# Full-Duplex 16-Bit SPI Register Target

This block is an SPI target that sits behind a host microcontroller and gives it access to four 12-bit control registers. Every transfer is one 16-bit frame, sent most significant bit first. The top three bits name a register and the next bit marks the frame as a read. The low twelve bits carry the value to write. While the host shifts a frame in, the block shifts back the current contents of the addressed register, so one transfer both reads and writes.

All logic runs on the system clock. The chip select, serial clock and data input are first passed through a two-stage synchronizer and then edge-detected. An accepted write is handed to the rest of the chip in two ways: as a one-cycle strobe per register with its data, and as the updated register image. The block carries out no side effects of a write. It does not decode the meaning of any field.

A five-state machine controls each frame:
- IDLE waits for chip select to fall.
- ADDR collects the three address bits. The last of these moves it to DATA.
- DATA collects the remaining bits. A seventeenth falling clock edge moves it to OVER.
- From DATA, a rise of chip select with exactly sixteen bits received leads to COMMIT. Any other count leads back to IDLE.
- A rise of chip select in ADDR or OVER returns to IDLE.
- COMMIT lasts one cycle and always returns to IDLE.

Top module: `spi_frame_regs`

## Requirements
- R1: After reset, the register image reads 0x400 for register 0 and zero for registers 1 to 3, no write strobe is active and the data output enable is low.
- R2: A frame puts the address in bits 15:13, the read flag in bit 12 and data in bits 11:0, sent MSB first. The target samples each input bit on a falling SCK edge, and SCK idles low. A frame with the read flag at 0, a mapped address and exactly 16 falling edges produces, after chip select rises, one strobe cycle on `wr_strobe_o[address]` with `wr_data_o` equal to bits 11:0. The register then holds that value.
- R3: A frame with the read flag at 1 produces no strobe and changes no register.
- R4: A frame with fewer or more than 16 falling SCK edges produces no strobe and changes no register.
- R5: Addresses 100 to 111 are unmapped. Writes to them produce no strobe, and reads of them return zero data.
- R6: The output changes on rising SCK edges. The 16 returned bits, in time order, are a 0, then the three address bits of the same frame (each one bit time after it was sent), then the 12 bits the addressed register held before the frame, MSB first.
- R7: The data output enable is low while chip select is high, so the pad is high-impedance. The enable is high during a frame.
- R8: At most one strobe bit is high in any cycle, and a strobe lasts one cycle.
- R9: A read issued directly after a write returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock from the host, idles low |
| spi_csn_i | input | 1 | Active-low chip select |
| spi_sdi_i | input | 1 | Serial data from the host |
| spi_sdo_o | output | 1 | Serial data to the host |
| spi_sdo_en_o | output | 1 | Output enable for the tristate data pad |
| wr_strobe_o | output | 4 | One-cycle write strobe, one bit per register |
| wr_data_o | output | 12 | Data of the accepted write |
| reg_q_o | output | 48 | Image of the four registers, register 0 in the low bits |

## Verification
The assertions rely on three assumptions about the inputs. Each SCK level is held for several system clocks. A SCK edge never coincides with a chip-select edge after synchronization. Chip select stays high for several clocks between frames. Under these assumptions, every falling edge seen while a frame is active is counted exactly once, and the frame count is stable when the commit decision is made. The bench holds each SCK phase for eight system clocks. It changes data only at rising SCK edges and adds half-bit gaps around chip-select edges, so all stimulus stays within these assumptions.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_OVER,
        ST_COMMIT
    } frame_state_t;

endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic sdi_i,
    output logic sdi_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic csn_rise_o,
    output logic csn_fall_o
);

    logic [STAGES:0]   sck_pipe;
    logic [STAGES:0]   csn_pipe;
    logic [STAGES-1:0] sdi_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            csn_pipe <= '1;
            sdi_pipe <= '0;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-1:0], sck_i};
            csn_pipe <= {csn_pipe[STAGES-1:0], csn_i};
            sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi_i};
        end
    end

    always_comb begin
        sdi_o      = sdi_pipe[STAGES-1];
        sck_rise_o = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
        sck_fall_o = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
        csn_rise_o = csn_pipe[STAGES-1] & ~csn_pipe[STAGES];
        csn_fall_o = ~csn_pipe[STAGES-1] & csn_pipe[STAGES];
    end

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 12,
    parameter int ADDR_W   = 3,
    parameter logic [NUM_REGS*DATA_W-1:0] RESET_IMAGE = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS-1:0]        we_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [NUM_REGS*DATA_W-1:0] image_o
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= RESET_IMAGE[g*DATA_W +: DATA_W];
            end else if (we_i[g]) begin
                regs_q[g] <= wdata_i;
            end
        end

        assign image_o[g*DATA_W +: DATA_W] = regs_q[g];

        // R3 / R4: a register moves only under its own strobe
        assert_reg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(we_i[g]) |-> $stable(regs_q[g]));

        // R2: a strobed write lands the presented data
        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(we_i[g]) |-> (regs_q[g] == $past(wdata_i)));
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr_i == i[ADDR_W-1:0]) begin
                rd_data_o = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 12,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdi_i,
    input  logic                sck_rise_i,
    input  logic                sck_fall_i,
    input  logic                csn_rise_i,
    input  logic                csn_fall_i,
    input  logic [DATA_W-1:0]   rd_data_i,
    output logic [ADDR_W-1:0]   rd_addr_o,
    output logic                sdo_o,
    output logic                sdo_en_o,
    output logic [NUM_REGS-1:0] wr_strobe_o,
    output logic [DATA_W-1:0]   wr_data_o
);

    localparam int FRAME_W = ADDR_W + 1 + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_MAX       = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_ADDR      = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(ADDR_W - 1);

    frame_state_t         state, state_nx;
    logic [CNT_W-1:0]     fall_cnt;
    logic [FRAME_W-1:0]   rx_sh;
    logic [DATA_W-1:0]    tx_sh;
    logic                 sdo_q;
    logic                 active;
    logic [ADDR_W-1:0]    frame_addr;
    logic                 frame_ro;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (csn_fall_i) state_nx = ST_ADDR;
            end
            ST_ADDR: begin
                if (csn_rise_i) begin
                    state_nx = ST_IDLE;
                end else if (sck_fall_i && fall_cnt == CNT_ADDR_LAST) begin
                    state_nx = ST_DATA;
                end
            end
            ST_DATA: begin
                if (csn_rise_i) begin
                    state_nx = (fall_cnt == CNT_FULL) ? ST_COMMIT : ST_IDLE;
                end else if (sck_fall_i && fall_cnt == CNT_FULL) begin
                    state_nx = ST_OVER;
                end
            end
            ST_OVER: begin
                if (csn_rise_i) state_nx = ST_IDLE;
            end
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign active    = (state == ST_ADDR) || (state == ST_DATA) || (state == ST_OVER);
    assign rd_addr_o = {rx_sh[ADDR_W-2:0], sdi_i};

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_cnt <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            sdo_q    <= 1'b0;
        end else if (state == ST_IDLE && csn_fall_i) begin
            fall_cnt <= '0;
            rx_sh    <= '0;
            sdo_q    <= 1'b0;
        end else if (active) begin
            if (sck_fall_i) begin
                rx_sh <= {rx_sh[FRAME_W-2:0], sdi_i};
                if (fall_cnt != CNT_MAX) fall_cnt <= fall_cnt + 1'b1;
                if (state == ST_ADDR && fall_cnt == CNT_ADDR_LAST) tx_sh <= rd_data_i;
            end
            if (sck_rise_i) begin
                if (fall_cnt == '0) begin
                    sdo_q <= 1'b0;
                end else if (fall_cnt <= CNT_ADDR) begin
                    sdo_q <= rx_sh[0];
                end else begin
                    sdo_q <= tx_sh[DATA_W-1];
                    tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign frame_addr = rx_sh[FRAME_W-1 -: ADDR_W];
    assign frame_ro   = rx_sh[DATA_W];

    // outputs
    always_comb begin
        sdo_o       = sdo_q;
        sdo_en_o    = active;
        wr_data_o   = rx_sh[DATA_W-1:0];
        wr_strobe_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (frame_addr == i[ADDR_W-1:0]) begin
                wr_strobe_o[i] = (state == ST_COMMIT) && !frame_ro;
            end
        end
    end

    assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe_o));

    assert_strobe_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_strobe_o) |=> (wr_strobe_o == '0));

    assert_full_frame_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_strobe_o) |-> ($past(fall_cnt) == CNT_FULL));

endmodule

// File: rtl/spi_frame_regs.sv
module spi_frame_regs #(
    parameter int NUM_REGS    = 4,
    parameter int DATA_W      = 12,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_REGS*DATA_W-1:0] RESET_IMAGE = 48'h000_000_000_400
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sck_i,
    input  logic                       spi_csn_i,
    input  logic                       spi_sdi_i,
    output logic                       spi_sdo_o,
    output logic                       spi_sdo_en_o,
    output logic [NUM_REGS-1:0]        wr_strobe_o,
    output logic [DATA_W-1:0]          wr_data_o,
    output logic [NUM_REGS*DATA_W-1:0] reg_q_o
);

    logic              sdi_s;
    logic              sck_rise, sck_fall, csn_rise, csn_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    spi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (spi_sck_i),
        .csn_i      (spi_csn_i),
        .sdi_i      (spi_sdi_i),
        .sdi_o      (sdi_s),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .csn_rise_o (csn_rise),
        .csn_fall_o (csn_fall)
    );

    spi_frame_fsm #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sdi_i       (sdi_s),
        .sck_rise_i  (sck_rise),
        .sck_fall_i  (sck_fall),
        .csn_rise_i  (csn_rise),
        .csn_fall_i  (csn_fall),
        .rd_data_i   (rd_data),
        .rd_addr_o   (rd_addr),
        .sdo_o       (spi_sdo_o),
        .sdo_en_o    (spi_sdo_en_o),
        .wr_strobe_o (wr_strobe_o),
        .wr_data_o   (wr_data_o)
    );

    spi_reg_bank #(
        .NUM_REGS    (NUM_REGS),
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .RESET_IMAGE (RESET_IMAGE)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_strobe_o),
        .wdata_i   (wr_data_o),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .image_o   (reg_q_o)
    );

    // R7: select held high long enough to pass the synchronizer keeps the pad released
    assert_sdo_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn_i && $past(spi_csn_i) && $past(spi_csn_i, 2) && $past(spi_csn_i, 3)
         && $past(spi_csn_i, 4) && $past(spi_csn_i, 5)) |-> !spi_sdo_en_o);

endmodule

// File: tb/test_spi_frame_regs.sv
module test_spi_frame_regs;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        csn = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo, sdo_en;
    logic [3:0]  wr_strobe;
    logic [11:0] wr_data;
    logic [47:0] reg_q;

    int checks = 0;
    int errors = 0;

    logic [11:0] model [8];
    logic [14:0] exp_q [$];

    always #4 clk = ~clk;

    spi_frame_regs i_spi_frame_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sck_i    (sck),
        .spi_csn_i    (csn),
        .spi_sdi_i    (sdi),
        .spi_sdo_o    (sdo),
        .spi_sdo_en_o (sdo_en),
        .wr_strobe_o  (wr_strobe),
        .wr_data_o    (wr_data),
        .reg_q_o      (reg_q)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] model_image();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    // driver: runs one transfer and pushes the write it expects
    task automatic spi_xfer(input logic [15:0] frame, input int nbits, input string req);
        logic [15:0] got;
        logic [15:0] want;
        logic [2:0]  a;
        got  = '0;
        a    = frame[15:13];
        want = {1'b0, a, model[a]};
        @(negedge clk);
        csn = 1'b0;
        repeat (H) @(negedge clk);
        check(sdo_en == 1'b1, "R7", "enable during frame", sdo_en, 1);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? frame[15-i] : 1'b0;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            if (i < 16) got[15-i] = sdo;
            sck = 1'b0;
            repeat (H) @(negedge clk);
        end
        if (nbits == 16 && !frame[12] && a < 3'd4) begin
            exp_q.push_back({a, frame[11:0]});
            model[a] = frame[11:0];
        end
        csn = 1'b1;
        repeat (3 * H) @(negedge clk);
        check(sdo_en == 1'b0, "R7", "enable after frame", sdo_en, 0);
        if (nbits >= 16) check(got == want, "R6", "returned frame", got, want);
        check(reg_q == model_image(), req, "register image", reg_q, model_image());
    endtask

    // monitor: pops expected writes as strobes appear
    always @(negedge clk) begin
        if (rst_n && wr_strobe != 4'b0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R4/R5", "unexpected strobe", wr_strobe, 0);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                check(wr_strobe == (4'b1 << e[14:12]), "R2/R8", "strobe", wr_strobe,
                      4'b1 << e[14:12]);
                check(wr_data == e[11:0], "R2", "write data", wr_data, e[11:0]);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog act=hung exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 12'h000;
        model[0] = 12'h400;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(reg_q == 48'h000_000_000_400, "R1", "reset image", reg_q, 48'h400);
        check(sdo_en == 1'b0, "R1", "reset enable", sdo_en, 0);
        check(wr_strobe == 4'b0, "R1", "reset strobe", wr_strobe, 0);

        spi_xfer({3'b000, 1'b1, 12'h000}, 16, "R3");   // read reset value
        spi_xfer({3'b001, 1'b0, 12'hABC}, 16, "R2");
        spi_xfer({3'b001, 1'b1, 12'h000}, 16, "R9");   // read back new value
        spi_xfer({3'b010, 1'b0, 12'h5A5}, 16, "R2");
        spi_xfer({3'b011, 1'b0, 12'hFFF}, 16, "R2");
        spi_xfer({3'b000, 1'b0, 12'h123}, 16, "R2");
        spi_xfer({3'b010, 1'b1, 12'h777}, 16, "R3");   // read flag blocks write
        spi_xfer({3'b001, 1'b0, 12'h111}, 15, "R4");   // short frame
        spi_xfer({3'b001, 1'b0, 12'h222}, 17, "R4");   // long frame
        spi_xfer({3'b101, 1'b0, 12'h333}, 16, "R5");   // unmapped write
        spi_xfer({3'b110, 1'b1, 12'h000}, 16, "R5");   // unmapped read
        spi_xfer({3'b011, 1'b0, 12'h0F0}, 16, "R2");
        spi_xfer({3'b011, 1'b1, 12'h000}, 16, "R9");
        spi_xfer({3'b100, 1'b1, 12'hFFF}, 16, "R5");

        repeat (4 * H) @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending writes", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule